// File: doc/BRIEF.md
# Control Endpoint Status and Command Register

This block holds the status and command register for the control endpoint (endpoint 0) of a USB device function. It sits between a small processor's 8-bit register bus and the USB protocol engine. The processor reads the register at any time and writes it to arm transmissions, acknowledge received packets, request a STALL handshake and acknowledge an aborted transfer. The protocol engine reports single-cycle events: packet received into the FIFO, IN packet delivered, control transfer ended early, protocol violation, and STALL handshake issued.

The register combines ordinary bits, write-one commands that return to zero by themselves, and bits that only the engine can set. Each qualifying engine event raises a one-cycle interrupt request. A premature end of a transfer issues a one-cycle FIFO flush pulse. It also blocks processor access to the FIFO until the processor acknowledges it. When an engine event that sets a bit and a processor write that clears the same bit land in one cycle, the event wins, so no event is lost.

Register bits, from bit 0 to bit 7: rx_ready, tx_ready, stall_seen, last_data, early_end, stall_req, ack_rx (command), ack_end (command).

Top module: `ep0_ctl_status_reg`

## Requirements
- R1: After a clock edge with `rst` high, the readback is 0x00 and `irq`, `fifo_flush` and `fifo_lock` are 0.
- R2: `ev_out_rcvd` sets rx_ready (bit 0) at the next edge, and `irq` is 1 for that one cycle.
- R3: A write with bit 6 set clears rx_ready. Bits 6 and 7 always read back as 0.
- R4: A write with bit 1 set sets tx_ready. When tx_ready is 1, `ev_in_sent` clears it and pulses `irq` for one cycle. When tx_ready is 0, `ev_in_sent` raises no `irq`.
- R5: `ev_proto_err` sets stall_seen (bit 2) and pulses `irq`. A write with bit 2 at 0 clears stall_seen, and a write with bit 2 at 1 leaves it unchanged.
- R6: last_data (bit 3) takes the value of bit 3 of every write.
- R7: `ev_xfer_abort` sets early_end (bit 4), pulses `irq`, and pulses `fifo_flush` for exactly one cycle. `fifo_lock` is 1 while early_end is 1. A write with bit 7 set clears early_end and leaves rx_ready unchanged.
- R8: A write with bit 5 set sets stall_req (bit 5) and clears rx_ready. `ev_stall_done` clears stall_req.
- R9: The single write 0x4A sets tx_ready and last_data and clears rx_ready in the same edge.
- R10: If `ev_out_rcvd` and a bit-6 write arrive in the same cycle, rx_ready ends at 1. If `ev_xfer_abort` and a bit-7 write arrive in the same cycle, early_end ends at 1.
- R11: Writes to bits 0 and 4 do not change rx_ready or early_end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_wr | input | 1 | Register write strobe |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Register readback |
| ev_out_rcvd | input | 1 | Engine: valid packet placed in FIFO |
| ev_in_sent | input | 1 | Engine: host received the IN packet |
| ev_xfer_abort | input | 1 | Engine: control transfer ended before the data stage finished |
| ev_proto_err | input | 1 | Engine: transaction ended on a protocol violation |
| ev_stall_done | input | 1 | Engine: STALL handshake issued |
| irq | output | 1 | One-cycle interrupt request |
| fifo_flush | output | 1 | One-cycle FIFO flush request |
| fifo_lock | output | 1 | Processor FIFO access blocked |

## Verification
The assertions assume that each engine event is a single-cycle pulse sampled at a clock edge. They also assume that the relations between events and the processor write in the same cycle are exactly the ones the requirements define. The stimulus drives events and writes only between clock edges and returns them to zero after one edge. The sweep builds every combination of the three engine-set bits and then applies each of the 256 write values. The same-cycle collisions of R10 are driven on purpose, so the set-wins priority is exercised rather than assumed.

// File: rtl/ep0_ctl_pkg.sv
package ep0_ctl_pkg;
    localparam int EP0_REG_W = 8;

    localparam int B_RX_READY   = 0;
    localparam int B_TX_READY   = 1;
    localparam int B_STALL_SEEN = 2;
    localparam int B_LAST_DATA  = 3;
    localparam int B_EARLY_END  = 4;
    localparam int B_STALL_REQ  = 5;
    localparam int B_ACK_RX     = 6;
    localparam int B_ACK_END    = 7;

    typedef struct packed {
        logic ack_end;
        logic ack_rx;
        logic stall_req;
        logic early_end;
        logic last_data;
        logic stall_seen;
        logic tx_ready;
        logic rx_ready;
    } ep0_reg_t;

    typedef struct packed {
        logic wr;
        logic set_tx;
        logic clr_stall_seen;
        logic last_val;
        logic set_stall_req;
        logic clr_rx;
        logic clr_early;
    } ep0_cmd_t;

    typedef struct packed {
        logic out_rcvd;
        logic in_sent;
        logic xfer_abort;
        logic proto_err;
        logic stall_done;
    } ep0_evt_t;

    function automatic logic set_clr(input logic cur, input logic set, input logic clr);
        return set | (cur & ~clr);
    endfunction
endpackage

// File: rtl/ep0_cpu_decode.sv
module ep0_cpu_decode
    import ep0_ctl_pkg::*;
(
    input  logic                 wr,
    input  logic [EP0_REG_W-1:0] wdata,
    output ep0_cmd_t             cmd
);
    logic unused_ro_bits;
    assign unused_ro_bits = ^{wdata[B_RX_READY], wdata[B_EARLY_END]};

    always_comb begin
        cmd                = '0;
        cmd.wr             = wr;
        cmd.set_tx         = wr & wdata[B_TX_READY];
        cmd.clr_stall_seen = wr & ~wdata[B_STALL_SEEN];
        cmd.last_val       = wdata[B_LAST_DATA];
        cmd.set_stall_req  = wr & wdata[B_STALL_REQ];
        cmd.clr_rx         = wr & (wdata[B_ACK_RX] | wdata[B_STALL_REQ]);
        cmd.clr_early      = wr & wdata[B_ACK_END];
    end
endmodule

// File: rtl/ep0_status_core.sv
module ep0_status_core
    import ep0_ctl_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  ep0_cmd_t cmd,
    input  ep0_evt_t evt,
    output ep0_reg_t state
);
    logic rx_q, tx_q, ss_q, ld_q, ee_q, sr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_q <= 1'b0;
            tx_q <= 1'b0;
            ss_q <= 1'b0;
            ld_q <= 1'b0;
            ee_q <= 1'b0;
            sr_q <= 1'b0;
        end else begin
            rx_q <= set_clr(rx_q, evt.out_rcvd, cmd.clr_rx);
            tx_q <= set_clr(tx_q, cmd.set_tx, evt.in_sent);
            ss_q <= set_clr(ss_q, evt.proto_err, cmd.clr_stall_seen);
            ld_q <= cmd.wr ? cmd.last_val : ld_q;
            ee_q <= set_clr(ee_q, evt.xfer_abort, cmd.clr_early);
            sr_q <= set_clr(sr_q, cmd.set_stall_req, evt.stall_done);
        end
    end

    always_comb begin
        state            = '0;
        state.rx_ready   = rx_q;
        state.tx_ready   = tx_q;
        state.stall_seen = ss_q;
        state.last_data  = ld_q;
        state.early_end  = ee_q;
        state.stall_req  = sr_q;
    end

    p_rx_set_r2: assert property (@(posedge clk) disable iff (rst)
        evt.out_rcvd |=> rx_q);
    p_ack_rx_r3: assert property (@(posedge clk) disable iff (rst)
        (cmd.clr_rx && !evt.out_rcvd) |=> !rx_q);
    p_tx_clear_r4: assert property (@(posedge clk) disable iff (rst)
        (evt.in_sent && !cmd.set_tx) |=> !tx_q);
    p_stall_seen_r5: assert property (@(posedge clk) disable iff (rst)
        evt.proto_err |=> ss_q);
    p_early_set_r7: assert property (@(posedge clk) disable iff (rst)
        evt.xfer_abort |=> ee_q);
    p_early_keep_rx_r7: assert property (@(posedge clk) disable iff (rst)
        (cmd.clr_early && !cmd.clr_rx && rx_q) |=> rx_q);
    p_stall_req_r8: assert property (@(posedge clk) disable iff (rst)
        (evt.stall_done && !cmd.set_stall_req) |=> !sr_q);
endmodule

// File: rtl/ep0_irq_gen.sv
module ep0_irq_gen
    import ep0_ctl_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  ep0_evt_t evt,
    input  logic     tx_ready,
    output logic     irq,
    output logic     fifo_flush
);
    logic irq_q, flush_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_q   <= 1'b0;
            flush_q <= 1'b0;
        end else begin
            irq_q   <= evt.out_rcvd | (evt.in_sent & tx_ready)
                     | evt.xfer_abort | evt.proto_err;
            flush_q <= evt.xfer_abort;
        end
    end

    assign irq        = irq_q;
    assign fifo_flush = flush_q;

    p_irq_in_r4: assert property (@(posedge clk) disable iff (rst)
        (evt.in_sent && tx_ready) |=> irq_q);
    p_irq_rx_r2: assert property (@(posedge clk) disable iff (rst)
        evt.out_rcvd |=> irq_q);
    p_flush_r7: assert property (@(posedge clk) disable iff (rst)
        evt.xfer_abort |=> flush_q);
endmodule

// File: rtl/ep0_ctl_status_reg.sv
module ep0_ctl_status_reg
    import ep0_ctl_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cpu_wr,
    input  logic [EP0_REG_W-1:0] cpu_wdata,
    output logic [EP0_REG_W-1:0] cpu_rdata,
    input  logic                 ev_out_rcvd,
    input  logic                 ev_in_sent,
    input  logic                 ev_xfer_abort,
    input  logic                 ev_proto_err,
    input  logic                 ev_stall_done,
    output logic                 irq,
    output logic                 fifo_flush,
    output logic                 fifo_lock
);
    ep0_cmd_t cmd;
    ep0_evt_t evt;
    ep0_reg_t state;

    assign evt.out_rcvd   = ev_out_rcvd;
    assign evt.in_sent    = ev_in_sent;
    assign evt.xfer_abort = ev_xfer_abort;
    assign evt.proto_err  = ev_proto_err;
    assign evt.stall_done = ev_stall_done;

    ep0_cpu_decode u_dec (
        .wr    (cpu_wr),
        .wdata (cpu_wdata),
        .cmd   (cmd)
    );

    ep0_status_core u_core (
        .clk   (clk),
        .rst   (rst),
        .cmd   (cmd),
        .evt   (evt),
        .state (state)
    );

    ep0_irq_gen u_irq (
        .clk        (clk),
        .rst        (rst),
        .evt        (evt),
        .tx_ready   (state.tx_ready),
        .irq        (irq),
        .fifo_flush (fifo_flush)
    );

    assign cpu_rdata = state;
    assign fifo_lock = state.early_end;

    p_reset_r1: assert property (@(posedge clk)
        rst |=> (cpu_rdata == '0 && !irq && !fifo_flush));
    p_lock_flush_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(fifo_lock) |-> fifo_flush);
    p_flush_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        (fifo_flush && !ev_xfer_abort) |=> !fifo_flush);
endmodule

// File: tb/test_ep0_ctl_status_reg.sv
module test_ep0_ctl_status_reg;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cpu_wr = 1'b0;
    logic [7:0] cpu_wdata = '0;
    logic [7:0] cpu_rdata;
    logic       ev_out_rcvd = 1'b0, ev_in_sent = 1'b0, ev_xfer_abort = 1'b0;
    logic       ev_proto_err = 1'b0, ev_stall_done = 1'b0;
    logic       irq, fifo_flush, fifo_lock;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    ep0_ctl_status_reg i_ep0_ctl_status_reg (
        .clk(clk), .rst(rst), .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata),
        .cpu_rdata(cpu_rdata), .ev_out_rcvd(ev_out_rcvd), .ev_in_sent(ev_in_sent),
        .ev_xfer_abort(ev_xfer_abort), .ev_proto_err(ev_proto_err),
        .ev_stall_done(ev_stall_done), .irq(irq), .fifo_flush(fifo_flush),
        .fifo_lock(fifo_lock)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
        cpu_wr = 1'b0; cpu_wdata = '0;
        ev_out_rcvd = 1'b0; ev_in_sent = 1'b0; ev_xfer_abort = 1'b0;
        ev_proto_err = 1'b0; ev_stall_done = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        tick();
        rst = 1'b0;
    endtask

    task automatic wr(input logic [7:0] v);
        cpu_wr = 1'b1; cpu_wdata = v;
    endtask

    initial begin
        #1000000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #3;
        do_reset();
        // R1
        chk("R1 readback", cpu_rdata, 8'h00);
        chk("R1 outputs", {5'b0, irq, fifo_flush, fifo_lock}, 8'h00);

        // R2
        ev_out_rcvd = 1'b1; tick();
        chk("R2 rx_ready set", cpu_rdata, 8'h01);
        chk("R2 irq pulse", {7'b0, irq}, 8'h01);
        tick();
        chk("R2 irq one cycle", {7'b0, irq}, 8'h00);

        // R4
        do_reset();
        wr(8'h02); tick();
        chk("R4 tx_ready set", cpu_rdata, 8'h02);
        chk("R4 no irq on cpu set", {7'b0, irq}, 8'h00);
        ev_in_sent = 1'b1; tick();
        chk("R4 tx_ready cleared", cpu_rdata, 8'h00);
        chk("R4 irq on send", {7'b0, irq}, 8'h01);
        ev_in_sent = 1'b1; tick();
        chk("R4 no irq when idle", {7'b0, irq}, 8'h00);

        // R8
        do_reset();
        ev_out_rcvd = 1'b1; tick();
        wr(8'h20); tick();
        chk("R8 stall_req set, rx cleared", cpu_rdata, 8'h20);
        ev_stall_done = 1'b1; tick();
        chk("R8 stall_req cleared", cpu_rdata, 8'h00);

        // R7 flush pulse and lock
        do_reset();
        ev_xfer_abort = 1'b1; tick();
        chk("R7 flush/lock/irq", {5'b0, irq, fifo_flush, fifo_lock}, 8'h07);
        tick();
        chk("R7 flush one cycle, lock held", {5'b0, irq, fifo_flush, fifo_lock}, 8'h01);
        wr(8'h80); tick();
        chk("R7 lock released", {7'b0, fifo_lock}, 8'h00);

        // R10
        do_reset();
        ev_out_rcvd = 1'b1; wr(8'h40); tick();
        chk("R10 rx set wins", cpu_rdata & 8'h01, 8'h01);
        ev_xfer_abort = 1'b1; wr(8'h80); tick();
        chk("R10 early_end set wins", cpu_rdata & 8'h10, 8'h10);

        // Sweep: every start state of the engine-set bits x every write value
        for (int s = 0; s < 8; s++) begin
            for (int v = 0; v < 256; v++) begin
                logic [7:0] vb;
                logic [7:0] exp;
                vb = v[7:0];
                do_reset();
                ev_out_rcvd = s[0]; ev_xfer_abort = s[1]; ev_proto_err = s[2];
                tick();
                if (v == 0) begin
                    chk("R2 R5 R7 event irq", {7'b0, irq}, {7'b0, |s[2:0]});
                    chk("R7 event flush", {7'b0, fifo_flush}, {7'b0, s[1]});
                end
                wr(vb); tick();
                exp = 8'h00;
                exp[0] = s[0] & ~vb[6] & ~vb[5];
                exp[1] = vb[1];
                exp[2] = s[2] & vb[2];
                exp[3] = vb[3];
                exp[4] = s[1] & ~vb[7];
                exp[5] = vb[5];
                chk("R3 R5 R6 R7 R8 R9 R11 sweep", cpu_rdata, exp);
                chk("R7 lock follows early_end", {7'b0, fifo_lock}, {7'b0, exp[4]});
            end
        end

        // R9 directed
        do_reset();
        ev_out_rcvd = 1'b1; tick();
        wr(8'h4A); tick();
        chk("R9 no-data-stage write", cpu_rdata, 8'h0A);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule